// File: doc/BRIEF.md
# Dual DAC Serial Control Interface

This block is the digital front end of a two-channel 12-bit voltage-output converter. A host writes 16-bit command words over a three-wire serial port: an active-low select, a serial clock and a data line. The front end decodes each word when the select line rises again. Each channel has two code registers in series. A holding register takes new data from the serial port. A converter register drives the channel's output code and only changes on an update command, so new values can be staged and then applied to both channels at once.

The same 16-bit shift register that collects incoming bits also drives a serial output. While a new word is being shifted in, the previous word comes out, so several devices can share one chain. A host command can shut down either channel or both. A low level on the lockout input blocks these shutdown commands. An active-low clear input returns all internal state to zero. A spare digital output can be set or cleared by command. All three serial pins are resynchronised to the system clock and their edges are found by oversampling.

Top module: `dsc_top`

## Requirements
- R1: A frame is 16 bits sent MSB first. Each bit is sampled on a rising serial clock edge while `cs_n` is low. The word is executed when `cs_n` rises. Bits 15:12 are the opcode and bits 11:0 are the data.
- R2: Opcode 0x1 loads the channel A holding register and opcode 0x2 loads the channel B holding register. Neither changes any output code.
- R3: Opcode 0x3 (channel A) and opcode 0x4 (channel B) load the holding register and set that channel's output code to the word's data.
- R4: Opcode 0x5 copies both holding registers into their output codes.
- R5: Opcodes 0x6 (A), 0x7 (B) and 0x8 (both) set the shutdown flags when `pd_lock_n` is high. The output codes and holding register contents are kept.
- R6: While `pd_lock_n` is low, opcodes 0x6, 0x7 and 0x8 change nothing.
- R7: Any command that writes a channel's output code (0x3, 0x4 or 0x5) clears that channel's shutdown flag.
- R8: Opcode 0x9 sets `user_out` and opcode 0xA clears it.
- R9: Opcode 0x0 and opcodes 0xB through 0xF change no output.
- R10: A low level on `clr_n` sets the codes, holding registers, shutdown flags, `user_out`, the shift register and `dout` to zero. Clear takes priority over a command executed in the same cycle.
- R11: When `cs_n` falls, `dout` shows bit 15 of the shift register. It moves to the next bit after each falling serial clock edge. So before rising edge k of a frame, `dout` equals bit 15-k of the previously shifted word.
- R12: Serial clock edges while `cs_n` is high neither shift the register nor execute a command.
- R13: After reset, every code, flag and output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, oversampled |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data in |
| clr_n | input | 1 | Active-low clear, sampled on clk |
| pd_lock_n | input | 1 | Low blocks shutdown commands |
| dout | output | 1 | Serial data out for chaining |
| user_out | output | 1 | Command-controlled digital output |
| code_a | output | 12 | Channel A converter code |
| code_b | output | 12 | Channel B converter code |
| shdn_a | output | 1 | Channel A shutdown flag |
| shdn_b | output | 1 | Channel B shutdown flag |

## Verification
Two functions can land in the same cycle. The first pair is a clear and the execution of a command at the select line's rising edge. The bench holds `clr_n` low across the end of a frame that loads and updates a channel, and expects all state, including the echoed word, to be zero. The second pair is a shutdown command and the lockout level it is decoded against. Random frames with random lockout levels are judged against a reference model in the bench that applies each shutdown only when lockout is high.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    parameter int unsigned OP_W   = 4;
    parameter int unsigned NUM_CH = 2;

    typedef enum logic [OP_W-1:0] {
        OP_NOP     = 4'h0,
        OP_LOAD_A  = 4'h1,
        OP_LOAD_B  = 4'h2,
        OP_LDUP_A  = 4'h3,
        OP_LDUP_B  = 4'h4,
        OP_UPD_ALL = 4'h5,
        OP_PD_A    = 4'h6,
        OP_PD_B    = 4'h7,
        OP_PD_ALL  = 4'h8,
        OP_UO_SET  = 4'h9,
        OP_UO_CLR  = 4'hA
    } dsc_op_e;

    // Per-channel vectors: bit 0 is channel A, bit 1 is channel B
    typedef struct packed {
        logic [NUM_CH-1:0] load;
        logic [NUM_CH-1:0] upd;
        logic [NUM_CH-1:0] pd;
        logic              uo_set;
        logic              uo_clr;
    } dsc_ctrl_t;

    function automatic dsc_ctrl_t dsc_decode(input logic [OP_W-1:0] op);
        dsc_ctrl_t c;
        c = '0;
        case (op)
            OP_LOAD_A:  c.load = 2'b01;
            OP_LOAD_B:  c.load = 2'b10;
            OP_LDUP_A:  begin c.load = 2'b01; c.upd = 2'b01; end
            OP_LDUP_B:  begin c.load = 2'b10; c.upd = 2'b10; end
            OP_UPD_ALL: c.upd = 2'b11;
            OP_PD_A:    c.pd = 2'b01;
            OP_PD_B:    c.pd = 2'b10;
            OP_PD_ALL:  c.pd = 2'b11;
            OP_UO_SET:  c.uo_set = 1'b1;
            OP_UO_CLR:  c.uo_clr = 1'b1;
            default:    c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
    parameter int unsigned      W       = 3,
    parameter int unsigned      STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dsc_shifter.sv
module dsc_shifter #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              din_s,
    output logic [WORD_W-1:0] word,
    output logic              strobe,
    output logic              dout
);
    logic sclk_q, csn_q;
    logic sclk_rise, sclk_fall, cs_fall;
    logic [WORD_W-1:0] sr;

    // Edge trackers follow the pins even during clear
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            csn_q  <= csn_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign cs_fall   = ~csn_s & csn_q;
    assign strobe    = csn_s & ~csn_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sr   <= '0;
            dout <= 1'b0;
        end else begin
            if (sclk_rise && !csn_s) sr <= {sr[WORD_W-2:0], din_s};
            if (cs_fall) dout <= sr[WORD_W-1];
            else if (sclk_fall && !csn_s) dout <= sr[WORD_W-1];
        end
    end

    assign word = sr;

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (csn_s && !clr) |=> $stable(sr));
    // R11
    echo_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_fall && !clr) |=> (dout == $past(sr[WORD_W-1])));
endmodule

// File: rtl/dsc_channel.sv
module dsc_channel #(
    parameter int unsigned CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              load,
    input  logic              upd,
    input  logic              pd_req,
    input  logic [CODE_W-1:0] data,
    output logic [CODE_W-1:0] code,
    output logic              pd
);
    logic [CODE_W-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hold <= '0;
            code <= '0;
            pd   <= 1'b0;
        end else begin
            if (load) hold <= data;
            if (upd)  code <= load ? data : hold;
            if (upd)         pd <= 1'b0;
            else if (pd_req) pd <= 1'b1;
        end
    end

    // R2
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!upd && !clr) |=> $stable(code));
    // R5
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !clr) |=> $stable(hold));
    // R7
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && !clr) |=> !pd);
    // R10
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (code == '0 && hold == '0 && !pd));
endmodule

// File: rtl/dsc_top.sv
module dsc_top
    import dsc_pkg::*;
#(
    parameter int unsigned CODE_W      = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              din,
    input  logic              clr_n,
    input  logic              pd_lock_n,
    output logic              dout,
    output logic              user_out,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              shdn_a,
    output logic              shdn_b
);
    localparam int unsigned WORD_W = OP_W + CODE_W;

    logic              sclk_s, csn_s, din_s;
    logic [WORD_W-1:0] word;
    logic              strobe, exec, clr;
    dsc_ctrl_t         ctrl;
    logic [CODE_W-1:0] code_arr [NUM_CH];
    logic [NUM_CH-1:0] pd_arr;

    assign clr = ~clr_n;

    dsc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sclk, cs_n, din}),
        .q   ({sclk_s, csn_s, din_s})
    );

    dsc_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .sclk_s (sclk_s),
        .csn_s  (csn_s),
        .din_s  (din_s),
        .word   (word),
        .strobe (strobe),
        .dout   (dout)
    );

    assign exec = strobe & ~clr;
    assign ctrl = dsc_decode(word[WORD_W-1 -: OP_W]);

    for (genvar ch = 0; ch < int'(NUM_CH); ch++) begin : g_ch
        dsc_channel #(.CODE_W(CODE_W)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr),
            .load   (exec & ctrl.load[ch]),
            .upd    (exec & ctrl.upd[ch]),
            .pd_req (exec & ctrl.pd[ch] & pd_lock_n),
            .data   (word[CODE_W-1:0]),
            .code   (code_arr[ch]),
            .pd     (pd_arr[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || clr)                user_out <= 1'b0;
        else if (exec && ctrl.uo_set)  user_out <= 1'b1;
        else if (exec && ctrl.uo_clr)  user_out <= 1'b0;
    end

    assign code_a = code_arr[0];
    assign code_b = code_arr[1];
    assign shdn_a = pd_arr[0];
    assign shdn_b = pd_arr[1];

    // R6
    lock_a_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(shdn_a) |-> $past(pd_lock_n));
    // R6
    lock_b_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(shdn_b) |-> $past(pd_lock_n));
    // R8
    uo_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $changed(user_out) |-> ($past(strobe) || $past(clr)));
    // R1
    frame_exec_chk: assert property (@(posedge clk) disable iff (rst)
        ($changed(code_a) || $changed(code_b)) |-> ($past(strobe) || $past(clr)));
endmodule

// File: tb/dsc_top_bench.sv
module dsc_top_bench;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst, sclk, cs_n, din, clr_n, pd_lock_n;
    logic dout, user_out, shdn_a, shdn_b;
    logic [11:0] code_a, code_b;

    int checks = 0;
    int fails  = 0;

    // reference model
    logic [11:0] m_hold_a, m_hold_b, m_code_a, m_code_b;
    logic        m_pd_a, m_pd_b, m_uo;
    logic [15:0] m_prev;

    always #5 clk = ~clk;

    dsc_top u_dsc_top (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
        .clr_n(clr_n), .pd_lock_n(pd_lock_n), .dout(dout),
        .user_out(user_out), .code_a(code_a), .code_b(code_b),
        .shdn_a(shdn_a), .shdn_b(shdn_b)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] op, input logic lock);
        case (op)
            4'h1, 4'h2:       return "R2";
            4'h3, 4'h4:       return "R3";
            4'h5:             return "R4";
            4'h6, 4'h7, 4'h8: return lock ? "R5" : "R6";
            4'h9, 4'hA:       return "R8";
            default:          return "R9";
        endcase
    endfunction

    function automatic void model_clear();
        m_hold_a = '0; m_hold_b = '0; m_code_a = '0; m_code_b = '0;
        m_pd_a = 1'b0; m_pd_b = 1'b0; m_uo = 1'b0; m_prev = '0;
    endfunction

    function automatic void model_exec(input logic [15:0] w, input logic lock);
        logic [3:0]  op;
        logic [11:0] d;
        op = w[15:12];
        d  = w[11:0];
        case (op)
            4'h1: m_hold_a = d;
            4'h2: m_hold_b = d;
            4'h3: begin m_hold_a = d; m_code_a = d; m_pd_a = 1'b0; end
            4'h4: begin m_hold_b = d; m_code_b = d; m_pd_b = 1'b0; end
            4'h5: begin m_code_a = m_hold_a; m_code_b = m_hold_b; m_pd_a = 1'b0; m_pd_b = 1'b0; end
            4'h6: if (lock) m_pd_a = 1'b1;
            4'h7: if (lock) m_pd_b = 1'b1;
            4'h8: if (lock) begin m_pd_a = 1'b1; m_pd_b = 1'b1; end
            4'h9: m_uo = 1'b1;
            4'hA: m_uo = 1'b0;
            default: ;
        endcase
        m_prev = w;
    endfunction

    task automatic check_outputs(input string req);
        check(req, {3'b0, code_a, code_b, shdn_a, shdn_b, user_out},
                   {3'b0, m_code_a, m_code_b, m_pd_a, m_pd_b, m_uo});
    endtask

    // Send one frame; echo of the previous word checked before each rise (R11)
    task automatic send(input logic [15:0] w, input logic clr_at_end);
        cs_n = 1'b0;
        wclk(HALF);
        for (int i = 15; i >= 0; i--) begin
            din = w[i];
            wclk(HALF);
            check("R11", {31'b0, dout}, {31'b0, m_prev[i]});
            sclk = 1'b1;
            wclk(HALF);
            sclk = 1'b0;
        end
        wclk(HALF);
        if (clr_at_end) clr_n = 1'b0;
        cs_n = 1'b1;
        wclk(HALF + 4);
        clr_n = 1'b1;
        wclk(2);
        if (clr_at_end) model_clear();
        else model_exec(w, pd_lock_n);
    endtask

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'h5EED_0B1E);
        rst = 1'b1; sclk = 1'b0; cs_n = 1'b1; din = 1'b0;
        clr_n = 1'b1; pd_lock_n = 1'b1;
        model_clear();
        wclk(5);
        rst = 1'b0;
        wclk(4);
        // R13 reset state
        check_outputs("R13");
        check("R13", {31'b0, dout}, 32'b0);

        // R1 framing: load+update A with a known value
        send(16'h3A5C, 1'b0);
        check_outputs("R1");
        // R2 load B only: code B unchanged
        send(16'h2123, 1'b0);
        check_outputs("R2");
        // R4 update both
        send(16'h5000, 1'b0);
        check_outputs("R4");
        // R5 power down both, holding kept
        send(16'h1FFF, 1'b0);
        send(16'h8000, 1'b0);
        check_outputs("R5");
        // R7 update A wakes A only
        send(16'h3001, 1'b0);
        check_outputs("R7");
        // R6 lockout blocks power-down of A
        pd_lock_n = 1'b0;
        send(16'h6000, 1'b0);
        check_outputs("R6");
        pd_lock_n = 1'b1;
        // R8 user output
        send(16'h9000, 1'b0);
        check_outputs("R8");
        // R9 no-op codes
        send(16'hB7FF, 1'b0);
        check_outputs("R9");
        send(16'h0ABC, 1'b0);
        check_outputs("R9");

        // R12 serial clock toggled while deselected
        for (int k = 0; k < 8; k++) begin
            din = k[0];
            wclk(HALF); sclk = 1'b1; wclk(HALF); sclk = 1'b0;
        end
        wclk(HALF);
        check_outputs("R12");
        send(16'h0000, 1'b0);   // echo checks confirm the register did not move
        check_outputs("R12");

        // R10 clear coinciding with command execution
        send(16'h4FFF, 1'b1);
        check_outputs("R10");
        check("R10", {31'b0, dout}, 32'b0);
        send(16'h5000, 1'b0);   // copies cleared holding registers
        check_outputs("R10");

        // random frames with random lockout
        for (int n = 0; n < 60; n++) begin
            logic [15:0] w;
            w = 16'($urandom);
            if (n % 9 == 0) w[11:0] = 12'hFFF;
            if (n % 11 == 0) w[11:0] = 12'h000;
            pd_lock_n = ($urandom % 4) != 0;
            send(w, 1'b0);
            check_outputs(req_of(w[15:12], pd_lock_n));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule